// File: doc/BRIEF.md
# Compact Zero-Compare Branch-and-Link Unit

This block recognises six compact branch-and-link instructions that each test one 32-bit register against zero. It decodes the instruction word, evaluates the signed comparison on the register value supplied by the caller, and produces three results. The first is a write request of the return address (the address after the branch) to register 31. The second is a taken flag with a matching flush request for the next sequential instruction, since these branches have no delay slot. The third is the PC-relative target.

The six conditions share only four primary opcodes. Two of those opcodes carry two conditions each. Those two are told apart by comparing the two 5-bit register fields: one field may be zero, or the two fields may be equal. Words with a family opcode whose register fields fit none of the patterns are reported as non-matching, so that another decoder can claim them. The link is written for every matching word, whether or not the branch is taken.

By default the results are registered: one clock after an accepted input, `out_valid` pulses for one cycle with the results. With `REG_OUT = 0`, the unit is purely combinational and `out_valid` follows `in_valid`.

Top module: `zcb_unit`

## Requirements
- R1: With instruction fields op = bits 31:26, ra = bits 25:21, rb = bits 20:16 and ra nonzero, the decode is as follows. op 110000 with rb zero gives cond code 1 (less-or-equal zero), and with rb equal to ra gives code 2 (greater-or-equal zero). op 111000 with rb zero gives code 3 (greater than zero), and with rb equal to ra gives code 4 (less than zero). op 011101 with rb zero gives code 5 (equal zero). op 011111 with rb zero gives code 6 (not equal zero).
- R2: Every other word drives `match` low, `cond` to 0, and `link_we`, `taken` and `flush` low. This covers other opcodes, ra zero, and rb nonzero when it is neither zero nor, where allowed, equal to ra.
- R3: For every matching word, `link_we` is 1, `link_idx` is 31 and `link_data` is pc+4 modulo 2^32, whether or not the branch is taken. When `link_we` is 0, `link_idx` is 0.
- R4: `taken` is 1 only for a matching word whose condition holds. The condition compares the register value, read as signed 32-bit, against zero.
- R5: `target` equals pc + 4 + sign_extend(bits 15:0 shifted left by one), modulo 2^32. Offset 0x7FFF adds 65534 and offset 0x8000 subtracts 65536.
- R6: `flush` equals `taken` on every valid output. `taken` is never 1 without `match`.
- R7: With REG_OUT=1, `out_valid` is 1 exactly in the cycle after `in_valid` was sampled high. While `out_valid` is 0, `match`, `link_we`, `taken` and `flush` are 0 and `cond` is 0. All of these are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction, PC and register value are presented |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rt_val | input | 32 | Value read from the register named by bits 25:21 |
| out_valid | output | 1 | Results valid strobe |
| match | output | 1 | Word belongs to the family |
| cond | output | 3 | Decoded condition code, 0 for none |
| link_we | output | 1 | Write request for the link register |
| link_idx | output | 5 | Link register index (31 when writing) |
| link_data | output | 32 | Return address pc+4 |
| taken | output | 1 | Branch condition holds |
| flush | output | 1 | Discard the next sequential instruction |
| target | output | 32 | Branch target address |

## Verification
The assertions assume that `instr` carries a known value on every clock edge after reset, because the decode pattern check inspects it even when `in_valid` is low. They also assume that `in_valid` itself is never unknown. The stimulus drives all inputs to zero from time zero and changes them only on falling edges, so every sampled value is defined. The sweep covers every register-field pair under six opcodes. It also crosses each condition with the extreme register values and the offset sign boundaries, including PC values near the top of the address space to force wraparound.

// File: rtl/zcb_pkg.sv
package zcb_pkg;
  localparam int XLEN     = 32;
  localparam int OFF_W    = 16;
  localparam int OP_W     = 6;
  localparam int REG_W    = 5;
  localparam int NUM_COND = 6;
  localparam int COND_W   = $clog2(NUM_COND + 1);

  typedef enum logic [COND_W-1:0] {
    CND_NONE = 3'd0,
    CND_LEZ  = 3'd1,
    CND_GEZ  = 3'd2,
    CND_GTZ  = 3'd3,
    CND_LTZ  = 3'd4,
    CND_EQZ  = 3'd5,
    CND_NEZ  = 3'd6
  } cond_e;

  // Primary opcode that carries condition slot i (slot i encodes cond i+1)
  function automatic logic [OP_W-1:0] slot_opcode(input int i);
    case (i)
      0, 1:    return 6'b110000;
      2, 3:    return 6'b111000;
      4:       return 6'b011101;
      default: return 6'b011111;
    endcase
  endfunction

  // Slot is selected by the second register field mirroring the first
  function automatic logic slot_mirrors(input int i);
    return (i == 1) || (i == 3);
  endfunction

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc,
                                                     input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] disp;
    disp = {{(XLEN-OFF_W-1){off[OFF_W-1]}}, off, 1'b0};
    return seq_addr(pc) + disp;
  endfunction

  function automatic logic zero_test(input cond_e c, input logic [XLEN-1:0] v);
    logic neg, zero;
    neg  = v[XLEN-1];
    zero = (v == '0);
    case (c)
      CND_LEZ: return neg | zero;
      CND_GEZ: return !neg;
      CND_GTZ: return !neg && !zero;
      CND_LTZ: return neg;
      CND_EQZ: return zero;
      CND_NEZ: return !zero;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/zcb_decode.sv
module zcb_decode
  import zcb_pkg::*;
(
  input  logic [OP_W-1:0]     opcode,
  input  logic [REG_W-1:0]    ra_f,
  input  logic [REG_W-1:0]    rb_f,
  output logic [NUM_COND-1:0] hit,
  output cond_e               cond,
  output logic                match
);
  logic ra_nz;
  assign ra_nz = (ra_f != '0);

  for (genvar g = 0; g < NUM_COND; g++) begin : g_slot
    logic rb_ok;
    if (slot_mirrors(g)) begin : g_mirror
      assign rb_ok = (rb_f == ra_f);
    end else begin : g_zero
      assign rb_ok = (rb_f == '0);
    end
    assign hit[g] = (opcode == slot_opcode(g)) && ra_nz && rb_ok;
  end

  always_comb begin
    cond = CND_NONE;
    for (int i = 0; i < NUM_COND; i++) begin
      if (hit[i]) cond = cond_e'(COND_W'(i + 1));
    end
  end

  assign match = |hit;
endmodule

// File: rtl/zcb_resolve.sv
module zcb_resolve
  import zcb_pkg::*;
(
  input  cond_e             cond,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [XLEN-1:0]   pc,
  input  logic [OFF_W-1:0]  offset,
  output logic              cond_true,
  output logic [XLEN-1:0]   link_data,
  output logic [XLEN-1:0]   target
);
  assign cond_true = zero_test(cond, rt_val);
  assign link_data = seq_addr(pc);
  assign target    = branch_target(pc, offset);
endmodule

// File: rtl/zcb_unit.sv
module zcb_unit
  import zcb_pkg::*;
#(
  parameter bit REG_OUT  = 1'b1,
  parameter int LINK_REG = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [XLEN-1:0]     instr,
  input  logic [XLEN-1:0]     pc,
  input  logic [XLEN-1:0]     rt_val,
  output logic                out_valid,
  output logic                match,
  output logic [COND_W-1:0]   cond,
  output logic                link_we,
  output logic [REG_W-1:0]    link_idx,
  output logic [XLEN-1:0]     link_data,
  output logic                taken,
  output logic                flush,
  output logic [XLEN-1:0]     target
);
  localparam int OP_LSB = XLEN - OP_W;
  localparam int RA_LSB = OP_LSB - REG_W;
  localparam int RB_LSB = RA_LSB - REG_W;
  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  // Named internal events
  logic [NUM_COND-1:0] dec_hit;
  cond_e               dec_cond;
  logic                dec_match;
  logic                res_true;
  logic [XLEN-1:0]     res_link;
  logic [XLEN-1:0]     res_target;
  logic                take_c;

  zcb_decode u_decode (
    .opcode (instr[XLEN-1:OP_LSB]),
    .ra_f   (instr[OP_LSB-1:RA_LSB]),
    .rb_f   (instr[RA_LSB-1:RB_LSB]),
    .hit    (dec_hit),
    .cond   (dec_cond),
    .match  (dec_match)
  );

  zcb_resolve u_resolve (
    .cond      (dec_cond),
    .rt_val    (rt_val),
    .pc        (pc),
    .offset    (instr[OFF_W-1:0]),
    .cond_true (res_true),
    .link_data (res_link),
    .target    (res_target)
  );

  assign take_c = dec_match && res_true;

  logic                v_q, m_q, t_q, f_q;
  logic [COND_W-1:0]   c_q;
  logic [XLEN-1:0]     l_q, a_q;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        m_q <= 1'b0;
        t_q <= 1'b0;
        f_q <= 1'b0;
        c_q <= CND_NONE;
        l_q <= '0;
        a_q <= '0;
      end else begin
        v_q <= in_valid;
        if (in_valid) begin
          m_q <= dec_match;
          t_q <= take_c;
          f_q <= take_c;
          c_q <= dec_cond;
          l_q <= res_link;
          a_q <= res_target;
        end else begin
          m_q <= 1'b0;
          t_q <= 1'b0;
          f_q <= 1'b0;
          c_q <= CND_NONE;
        end
      end
    end

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    assert_valid_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
  end else begin : g_comb
    always_comb begin
      v_q = in_valid;
      m_q = in_valid && dec_match;
      t_q = in_valid && take_c;
      f_q = in_valid && take_c;
      c_q = in_valid ? dec_cond : CND_NONE;
      l_q = res_link;
      a_q = res_target;
    end
  end

  assign out_valid = v_q;
  assign match     = m_q;
  assign cond      = c_q;
  assign link_we   = m_q;
  assign link_idx  = m_q ? LINK_IDX : '0;
  assign link_data = l_q;
  assign taken     = t_q;
  assign flush     = f_q;
  assign target    = a_q;

  // At most one decode pattern fires for any word
  assert_one_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_hit));
  // Decoded condition code and match flag agree
  assert_cond_tracks_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (match == (cond != CND_NONE)));
  // Link request always goes to the link register
  assert_link_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (link_we && link_idx == LINK_IDX));
  // A taken branch needs a decoded instruction
  assert_taken_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> match);
  // Quiet outputs when no result is presented
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(match || taken || flush || link_we));
endmodule

// File: tb/test_zcb_unit.sv
`timescale 1ns/1ps
module test_zcb_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic [31:0] rt_val = '0;
  logic        out_valid, match, link_we, taken, flush;
  logic [2:0]  cond;
  logic [4:0]  link_idx;
  logic [31:0] link_data, target;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  zcb_unit i_zcb_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .rt_val(rt_val), .out_valid(out_valid), .match(match), .cond(cond),
    .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
    .taken(taken), .flush(flush), .target(target)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected condition code from the field rules
  function automatic int exp_cond(input logic [5:0] op, input logic [4:0] ra,
                                  input logic [4:0] rb);
    if (ra == 0) return 0;
    if (op == 6'b110000) return (rb == 0) ? 1 : ((rb == ra) ? 2 : 0);
    if (op == 6'b111000) return (rb == 0) ? 3 : ((rb == ra) ? 4 : 0);
    if (op == 6'b011101) return (rb == 0) ? 5 : 0;
    if (op == 6'b011111) return (rb == 0) ? 6 : 0;
    return 0;
  endfunction

  function automatic bit exp_taken(input int c, input logic [31:0] v);
    longint s;
    s = longint'($signed(v));
    case (c)
      1: return s <= 0;
      2: return s >= 0;
      3: return s > 0;
      4: return s < 0;
      5: return s == 0;
      6: return s != 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_target(input logic [31:0] p, input logic [15:0] off);
    longint t;
    t = longint'(p) + 4 + 2 * longint'($signed(off));
    return t[31:0];
  endfunction

  task automatic run_one(input logic [5:0] op, input logic [4:0] ra, input logic [4:0] rb,
                         input logic [15:0] off, input logic [31:0] p,
                         input logic [31:0] v, input bit idle_check);
    int  c;
    bit  tk;
    logic [31:0] lnk;
    c   = exp_cond(op, ra, rb);
    tk  = exp_taken(c, v);
    lnk = p + 32'd4;
    @(negedge clk);
    instr = {op, ra, rb, off};
    pc = p;
    rt_val = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R7", "out_valid", 32'(out_valid), 32'd1);
    if (c != 0) begin
      chk(match == 1'b1, "R1", "match", 32'(match), 32'd1);
      chk(int'(cond) == c, "R1", "cond", 32'(cond), 32'(c));
      chk(link_we == 1'b1 && link_idx == 5'd31, "R3", "link_we/idx",
          {link_we, 26'd0, link_idx}, {1'b1, 26'd0, 5'd31});
      chk(link_data == lnk, "R3", "link_data", link_data, lnk);
      chk(taken == tk, "R4", "taken", 32'(taken), 32'(tk));
      chk(target == exp_target(p, off), "R5", "target", target, exp_target(p, off));
    end else begin
      chk(!match && cond == 3'd0, "R2", "match/cond", {28'd0, match, cond}, 32'd0);
      chk(!link_we && !taken, "R2", "link_we/taken", {link_we, taken}, 32'd0);
      chk(link_idx == 5'd0, "R3", "link_idx idle", 32'(link_idx), 32'd0);
    end
    chk(flush == taken, "R6", "flush", 32'(flush), 32'(taken));
    if (idle_check) begin
      @(negedge clk);
      chk(!out_valid && !match && !taken && !flush && !link_we && cond == 3'd0, "R7",
          "idle outputs", {out_valid, match, taken, flush, link_we, cond}, 32'd0);
    end
  endtask

  initial begin
    logic [5:0]  ops [6];
    logic [31:0] vals [7];
    logic [15:0] offs [5];
    logic [31:0] pcs [3];
    logic [4:0]  ras [3];
    int n;
    ops  = '{6'b110000, 6'b111000, 6'b011101, 6'b011111, 6'b000000, 6'b110001};
    vals = '{32'h0, 32'hFFFFFFFF, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'h2, 32'hFFFFFFFE};
    offs = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    pcs  = '{32'h0, 32'hFFFFFFF8, 32'h0040_0000};
    ras  = '{5'd1, 5'd5, 5'd31};

    repeat (3) @(negedge clk);
    // Reset state
    chk(!out_valid && !match && !link_we && !taken && !flush && cond == 3'd0, "R7",
        "reset outputs", {out_valid, match, link_we, taken, flush, cond}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !match, "R7", "after reset", {out_valid, match}, 32'd0);

    // R1/R4/R5: each condition crossed with boundary values, offsets and PCs
    n = 0;
    for (int s = 0; s < 6; s++) begin
      for (int r = 0; r < 3; r++) begin
        for (int vi = 0; vi < 7; vi++) begin
          for (int oi = 0; oi < 5; oi++) begin
            for (int pi = 0; pi < 3; pi++) begin
              logic [5:0] op;
              logic [4:0] rb;
              op = (s < 2) ? 6'b110000 : (s < 4) ? 6'b111000 : (s == 4) ? 6'b011101 : 6'b011111;
              rb = (s == 1 || s == 3) ? ras[r] : 5'd0;
              run_one(op, ras[r], rb, offs[oi], pcs[pi], vals[vi], (n % 8) == 0);
              n++;
            end
          end
        end
      end
    end

    // R1/R2: every register-field pair under family and neighbouring opcodes
    for (int o = 0; o < 6; o++) begin
      for (int ra = 0; ra < 32; ra++) begin
        for (int rb = 0; rb < 32; rb++) begin
          logic [31:0] v;
          v = rb[0] ? 32'hFFFFFFFF : (ra[0] ? 32'h0 : 32'h1);
          run_one(ops[o], 5'(ra), 5'(rb), {5'(ra), 5'(rb), 6'h2A},
                  {5'(rb), 5'(ra), 22'h3FFFF0}, v, (rb % 16) == 0);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule